// File: doc/BRIEF.md
# Secure Debug Permission Control Register

This block is a 32-bit configuration register for a processor core. It decides what debug and performance-monitor activity is allowed while the core runs in Secure state. Software reaches it through a coprocessor-style system-register access. The block compares the access encoding with its own and checks the requester's exception level and security state. A granted read returns the stored value one cycle later. A granted write updates the register at the clock edge that samples the request. Any access that is refused or does not match raises a one-cycle undefined-instruction indication.

Five bits carry state and all other bits are tied to zero. A permission network combines the stored bits with authentication inputs and produces a set of enables. These cover Secure privileged debug exceptions, Secure user-mode debug exceptions, Secure event counting and software-breakpoint events. They also cover whether an external debugger may reach the breakpoint/watchpoint registers and the performance-monitor registers. A further enable gives the privileged debug permission for the current security state. In Non-secure state the stored privileged-debug field plays no part in it.

Top module: `sec_dbg_ctrl_reg`

## Requirements
- R1: Only bits 21, 20, 17, 15 and 14 are stored. Every other bit reads as zero whatever value is written, so a granted write of all ones reads back as 0x0032C000.
- R2: After reset the stored value is zero. With all authentication inputs low, this gives `sec_priv_dbg_en`=0, `sec_user_dbg_en`=0, `sec_count_en`=0, `ext_pmu_access`=1 and `ext_bpwp_access`=1.
- R3: An access is granted only when `cur_el`=3 (either value of `ns_state`), or when `cur_el`=1 with `ns_state`=0. EL0, EL2 and Non-secure EL1 are refused.
- R4: An access matches only when `acc_cp`=15, `acc_op1`=0, `acc_crn`=1, `acc_crm`=3 and `acc_op2`=1. A non-matching access is treated as refused.
- R5: A refused access leaves the register unchanged. In the cycle after the request it drives `acc_undef`=1 and `acc_rdata`=0, and `acc_undef` returns to 0 after that unless another refused request follows.
- R6: A granted read (`acc_write`=0) drives the stored value on `acc_rdata` in the cycle after the request. A granted write (`acc_write`=1) is visible to a read issued in the next cycle. `acc_rdata` is 0 for writes and idle cycles.
- R7: Bits [15:14] set the Secure privileged debug mode. With 11, `sec_priv_dbg_en`=1. With 10, `sec_priv_dbg_en`=0. With 00, `sec_priv_dbg_en` follows `auth_sec_dbg`. The reserved value 01 is stored as written and behaves like 00.
- R8: `sec_user_dbg_en` is 1 when `sec_priv_dbg_en` is 1, and otherwise follows `sec_user_dbg_req`.
- R9: `sec_count_en` is 1 when bit 17 is 1 or when `auth_sec_cnt` is 1.
- R10: `ext_pmu_access` is 0 only when bit 21 is 1 and `auth_ext_ovr` is 0. `ext_bpwp_access` is 0 only when bit 20 is 1 and `auth_ext_ovr` is 0.
- R11: While `ns_state`=1, `cur_priv_dbg_en` follows `auth_ns_dbg` and bits [15:14] have no effect on it. While `ns_state`=0, it equals `sec_priv_dbg_en`. `swbkpt_dbg_en` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | System-register access request this cycle |
| acc_write | input | 1 | 1 = move to register (write), 0 = move from register (read) |
| acc_cp | input | 4 | Coprocessor number of the access |
| acc_op1 | input | 3 | First opcode field |
| acc_crn | input | 4 | Primary register field |
| acc_crm | input | 4 | Secondary register field |
| acc_op2 | input | 3 | Second opcode field |
| acc_wdata | input | 32 | Write data |
| cur_el | input | 2 | Exception level of the requester (0..3) |
| ns_state | input | 1 | 1 = Non-secure state, 0 = Secure state |
| auth_sec_dbg | input | 1 | Authentication: Secure invasive debug allowed |
| auth_ns_dbg | input | 1 | Authentication: Non-secure invasive debug allowed |
| auth_sec_cnt | input | 1 | Authentication: Secure event counting allowed |
| auth_ext_ovr | input | 1 | Authentication: override for external debugger register access |
| sec_user_dbg_req | input | 1 | Separate Secure user-mode debug enable |
| acc_rdata | output | 32 | Read data, one cycle after the request |
| acc_undef | output | 1 | Undefined-instruction indication, one cycle after the request |
| sec_priv_dbg_en | output | 1 | Secure privileged debug exceptions enabled |
| sec_user_dbg_en | output | 1 | Secure user-mode debug exceptions enabled |
| cur_priv_dbg_en | output | 1 | Privileged debug enable for the current security state |
| swbkpt_dbg_en | output | 1 | Software-breakpoint debug events enabled |
| sec_count_en | output | 1 | Secure event counting enabled |
| ext_bpwp_access | output | 1 | External debugger may reach breakpoint/watchpoint registers |
| ext_pmu_access | output | 1 | External debugger may reach performance-monitor registers |

## Verification
The assertions check several rules on every cycle. Reserved bits of the stored value stay zero. A refused access leaves the register unchanged and returns zero data. An EL0 or EL2 request is always followed by an undefined indication. The user-mode enable never drops while the privileged enable is set. A mode of 10 in Secure state never yields a privileged enable. Some behaviour only the bench's scenarios can show: the actual values read back after each write, the handling of the reserved mode encoding, and the authentication inputs taking effect in the legacy and override cases. So can the one-cycle shape of the undefined pulse and the Non-secure-state switch of the current-state enable.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
    localparam int DATA_W       = 32;
    localparam int POS_PMU_DIS  = 21;
    localparam int POS_BPWP_DIS = 20;
    localparam int POS_CNT_EN   = 17;
    localparam int POS_MODE_LO  = 14;
    localparam int MODE_W       = 2;

    localparam logic [DATA_W-1:0] FIELD_MASK =
        (DATA_W'(1) << POS_PMU_DIS) |
        (DATA_W'(1) << POS_BPWP_DIS) |
        (DATA_W'(1) << POS_CNT_EN) |
        (DATA_W'((1 << MODE_W) - 1) << POS_MODE_LO);

    typedef enum logic [MODE_W-1:0] {
        MODE_LEGACY = 2'b00,
        MODE_RSVD   = 2'b01,
        MODE_OFF    = 2'b10,
        MODE_ON     = 2'b11
    } priv_mode_e;

    typedef struct packed {
        logic       pmu_dis;
        logic       bpwp_dis;
        logic       cnt_en;
        priv_mode_e mode;
    } sdc_fields_t;
endpackage

// File: rtl/sdc_access_gate.sv
module sdc_access_gate #(
    parameter logic [3:0] CP_NUM  = 4'd15,
    parameter logic [2:0] OP1_VAL = 3'd0,
    parameter logic [3:0] CRN_VAL = 4'd1,
    parameter logic [3:0] CRM_VAL = 4'd3,
    parameter logic [2:0] OP2_VAL = 3'd1
) (
    input  logic [3:0] acc_cp,
    input  logic [2:0] acc_op1,
    input  logic [3:0] acc_crn,
    input  logic [3:0] acc_crm,
    input  logic [2:0] acc_op2,
    input  logic [1:0] cur_el,
    input  logic       ns_state,
    output logic       grant
);
    logic enc_hit;
    logic level_ok;

    always_comb begin
        enc_hit  = (acc_cp == CP_NUM) && (acc_op1 == OP1_VAL) &&
                   (acc_crn == CRN_VAL) && (acc_crm == CRM_VAL) &&
                   (acc_op2 == OP2_VAL);
        // EL3 regardless of security bit; EL1 only when Secure
        level_ok = (cur_el == 2'd3) || ((cur_el == 2'd1) && !ns_state);
        grant    = enc_hit && level_ok;
    end
endmodule

// File: rtl/sdc_field_store.sv
module sdc_field_store
    import sdc_pkg::*;
#(
    parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              grant,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              acc_undef,
    output sdc_fields_t       fields
);
    typedef struct packed {
        logic [DATA_W-1:0] cfg;
        logic [DATA_W-1:0] rdata;
        logic              undef;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        st_d.undef = acc_valid && !grant;
        if (acc_valid && grant) begin
            if (acc_write) begin
                st_d.cfg = acc_wdata & FIELD_MASK;
            end else begin
                st_d.rdata = st_q.cfg;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg   <= RESET_VAL & FIELD_MASK;
            st_q.rdata <= '0;
            st_q.undef <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        acc_rdata       = st_q.rdata;
        acc_undef       = st_q.undef;
        fields.pmu_dis  = st_q.cfg[POS_PMU_DIS];
        fields.bpwp_dis = st_q.cfg[POS_BPWP_DIS];
        fields.cnt_en   = st_q.cfg[POS_CNT_EN];
        fields.mode     = priv_mode_e'(st_q.cfg[POS_MODE_LO +: MODE_W]);
    end

    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg & ~FIELD_MASK) == '0);

    // R5
    refused_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.undef |-> (st_q.cfg == $past(st_q.cfg)));

    // R5
    refused_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.undef |-> (st_q.rdata == '0));
endmodule

// File: rtl/sdc_perm_net.sv
module sdc_perm_net
    import sdc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  sdc_fields_t fields,
    input  logic        ns_state,
    input  logic        auth_sec_dbg,
    input  logic        auth_ns_dbg,
    input  logic        auth_sec_cnt,
    input  logic        auth_ext_ovr,
    input  logic        sec_user_dbg_req,
    output logic        sec_priv_dbg_en,
    output logic        sec_user_dbg_en,
    output logic        cur_priv_dbg_en,
    output logic        swbkpt_dbg_en,
    output logic        sec_count_en,
    output logic        ext_bpwp_access,
    output logic        ext_pmu_access
);
    always_comb begin
        unique case (fields.mode)
            MODE_ON:  sec_priv_dbg_en = 1'b1;
            MODE_OFF: sec_priv_dbg_en = 1'b0;
            default:  sec_priv_dbg_en = auth_sec_dbg; // legacy and reserved
        endcase
        sec_user_dbg_en = sec_priv_dbg_en || sec_user_dbg_req;
        cur_priv_dbg_en = ns_state ? auth_ns_dbg : sec_priv_dbg_en;
        swbkpt_dbg_en   = 1'b1;
        sec_count_en    = fields.cnt_en || auth_sec_cnt;
        ext_bpwp_access = !fields.bpwp_dis || auth_ext_ovr;
        ext_pmu_access  = !fields.pmu_dis || auth_ext_ovr;
    end

    // R8
    user_follows_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_priv_dbg_en |-> sec_user_dbg_en);

    // R7
    mode_off_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fields.mode == MODE_OFF && !ns_state) |-> !cur_priv_dbg_en);

    // R10
    pmu_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        auth_ext_ovr |-> (ext_pmu_access && ext_bpwp_access));
endmodule

// File: rtl/sec_dbg_ctrl_reg.sv
module sec_dbg_ctrl_reg
    import sdc_pkg::*;
#(
    parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [3:0]        acc_cp,
    input  logic [2:0]        acc_op1,
    input  logic [3:0]        acc_crn,
    input  logic [3:0]        acc_crm,
    input  logic [2:0]        acc_op2,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [1:0]        cur_el,
    input  logic              ns_state,
    input  logic              auth_sec_dbg,
    input  logic              auth_ns_dbg,
    input  logic              auth_sec_cnt,
    input  logic              auth_ext_ovr,
    input  logic              sec_user_dbg_req,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              acc_undef,
    output logic              sec_priv_dbg_en,
    output logic              sec_user_dbg_en,
    output logic              cur_priv_dbg_en,
    output logic              swbkpt_dbg_en,
    output logic              sec_count_en,
    output logic              ext_bpwp_access,
    output logic              ext_pmu_access
);
    logic        grant;
    sdc_fields_t fields;

    sdc_access_gate u_gate (
        .acc_cp   (acc_cp),
        .acc_op1  (acc_op1),
        .acc_crn  (acc_crn),
        .acc_crm  (acc_crm),
        .acc_op2  (acc_op2),
        .cur_el   (cur_el),
        .ns_state (ns_state),
        .grant    (grant)
    );

    sdc_field_store #(.RESET_VAL(RESET_VAL)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .grant     (grant),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata),
        .acc_undef (acc_undef),
        .fields    (fields)
    );

    sdc_perm_net u_perm (
        .clk              (clk),
        .rst_n            (rst_n),
        .fields           (fields),
        .ns_state         (ns_state),
        .auth_sec_dbg     (auth_sec_dbg),
        .auth_ns_dbg      (auth_ns_dbg),
        .auth_sec_cnt     (auth_sec_cnt),
        .auth_ext_ovr     (auth_ext_ovr),
        .sec_user_dbg_req (sec_user_dbg_req),
        .sec_priv_dbg_en  (sec_priv_dbg_en),
        .sec_user_dbg_en  (sec_user_dbg_en),
        .cur_priv_dbg_en  (cur_priv_dbg_en),
        .swbkpt_dbg_en    (swbkpt_dbg_en),
        .sec_count_en     (sec_count_en),
        .ext_bpwp_access  (ext_bpwp_access),
        .ext_pmu_access   (ext_pmu_access)
    );

    // R3
    low_levels_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (cur_el == 2'd0 || cur_el == 2'd2)) |=> acc_undef);
endmodule

// File: tb/tb_sec_dbg_ctrl_reg.sv
module tb_sec_dbg_ctrl_reg;
    localparam logic [31:0] MASK = 32'h0032_C000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [3:0]  acc_cp = 4'd15, acc_crn = 4'd1, acc_crm = 4'd3;
    logic [2:0]  acc_op1 = 3'd0, acc_op2 = 3'd1;
    logic [31:0] acc_wdata = '0;
    logic [1:0]  cur_el = 2'd1;
    logic        ns_state = 1'b0;
    logic        auth_sec_dbg = 1'b0, auth_ns_dbg = 1'b0, auth_sec_cnt = 1'b0;
    logic        auth_ext_ovr = 1'b0, sec_user_dbg_req = 1'b0;
    logic [31:0] acc_rdata;
    logic        acc_undef, sec_priv_dbg_en, sec_user_dbg_en, cur_priv_dbg_en;
    logic        swbkpt_dbg_en, sec_count_en, ext_bpwp_access, ext_pmu_access;

    always #4 clk = ~clk;

    sec_dbg_ctrl_reg dut (.*);

    typedef struct {
        logic [31:0] rd;
        logic        ud;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_cmp = 0, n_bad = 0;
    logic [31:0] model = '0;

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_cmp++;
            if (acc_rdata !== e.rd || acc_undef !== e.ud) begin
                n_bad++;
                $display("FAIL %s: rdata=%h undef=%b expected rdata=%h undef=%b",
                         e.tag, acc_rdata, acc_undef, e.rd, e.ud);
            end
        end
    end

    task automatic access(input logic wr, input logic [1:0] el, input logic ns,
                          input logic [31:0] wd, input logic enc_ok, input string tag);
        exp_t e;
        logic ok;
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; cur_el = el; ns_state = ns;
        acc_wdata = wd; acc_crm = enc_ok ? 4'd3 : 4'd2;
        ok = enc_ok && (el == 2'd3 || (el == 2'd1 && !ns));
        e.rd = (ok && !wr) ? model : 32'h0;
        e.ud = !ok;
        e.tag = tag;
        if (ok && wr) model = wd & MASK;
        @(posedge clk);
        #1;
        acc_valid = 1'b0; acc_crm = 4'd3;
        sb.push_back(e);
    endtask

    task automatic idle(input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        e.rd = 32'h0; e.ud = 1'b0; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R2 reset state
        chk(sec_priv_dbg_en, 1'b0, "R2 priv");
        chk(sec_user_dbg_en, 1'b0, "R2 user");
        chk(sec_count_en, 1'b0, "R2 count");
        chk(ext_pmu_access, 1'b1, "R2 pmu");
        chk(ext_bpwp_access, 1'b1, "R2 bpwp");
        chk(acc_undef, 1'b0, "R2 undef");
        access(1'b0, 2'd1, 1'b0, 32'h0, 1'b1, "R2 read reset value");

        // R1 masking, R6 write then read
        access(1'b1, 2'd3, 1'b0, 32'hFFFF_FFFF, 1'b1, "R6 write all ones");
        access(1'b0, 2'd1, 1'b0, 32'h0, 1'b1, "R1 reserved bits zero");
        settle();
        chk(sec_priv_dbg_en, 1'b1, "R7 mode 11 on");
        chk(sec_count_en, 1'b1, "R9 bit17 set");
        chk(ext_pmu_access, 1'b0, "R10 pmu blocked");
        chk(ext_bpwp_access, 1'b0, "R10 bpwp blocked");
        auth_ext_ovr = 1'b1;
        settle();
        chk(ext_pmu_access, 1'b1, "R10 pmu override");
        chk(ext_bpwp_access, 1'b1, "R10 bpwp override");
        auth_ext_ovr = 1'b0;

        // R3 refused levels, R5 unchanged and one-cycle pulse
        access(1'b1, 2'd0, 1'b0, 32'h0, 1'b1, "R3 EL0 write refused");
        idle("R5 undef drops");
        access(1'b1, 2'd2, 1'b0, 32'h0, 1'b1, "R3 EL2 write refused");
        access(1'b1, 2'd1, 1'b1, 32'h0, 1'b1, "R3 NS EL1 write refused");
        access(1'b0, 2'd1, 1'b1, 32'h0, 1'b1, "R5 NS EL1 read zero data");
        access(1'b0, 2'd3, 1'b1, 32'h0, 1'b1, "R5 value unchanged");
        // R4 encoding mismatch
        access(1'b0, 2'd3, 1'b0, 32'h0, 1'b0, "R4 mismatch read");
        access(1'b1, 2'd3, 1'b0, 32'h0, 1'b0, "R4 mismatch write");
        access(1'b0, 2'd1, 1'b0, 32'h0, 1'b1, "R4 value unchanged");

        // R7 mode 10 via EL3 Non-secure, R8 user input
        access(1'b1, 2'd3, 1'b1, 32'h0000_8000, 1'b1, "R3 EL3 NS write");
        access(1'b0, 2'd1, 1'b0, 32'h0, 1'b1, "R6 read mode 10");
        ns_state = 1'b0; auth_sec_dbg = 1'b1; sec_user_dbg_req = 1'b0;
        settle();
        chk(sec_priv_dbg_en, 1'b0, "R7 mode 10 off");
        chk(cur_priv_dbg_en, 1'b0, "R11 secure follows priv");
        chk(sec_user_dbg_en, 1'b0, "R8 user off");
        chk(sec_count_en, 1'b0, "R9 count off");
        sec_user_dbg_req = 1'b1;
        settle();
        chk(sec_user_dbg_en, 1'b1, "R8 user from input");
        sec_user_dbg_req = 1'b0;

        // R7 reserved 01 behaves like legacy
        access(1'b1, 2'd1, 1'b0, 32'h0000_4000, 1'b1, "R7 write mode 01");
        access(1'b0, 2'd1, 1'b0, 32'h0, 1'b1, "R7 mode 01 stored");
        auth_sec_dbg = 1'b1;
        settle();
        chk(sec_priv_dbg_en, 1'b1, "R7 mode 01 auth high");
        chk(sec_user_dbg_en, 1'b1, "R8 user inherits priv");
        auth_sec_dbg = 1'b0;
        settle();
        chk(sec_priv_dbg_en, 1'b0, "R7 mode 01 auth low");

        // R7 legacy 00, R9 counting override
        access(1'b1, 2'd1, 1'b0, 32'h0, 1'b1, "R7 write mode 00");
        auth_sec_dbg = 1'b1; auth_sec_cnt = 1'b1;
        settle();
        chk(sec_priv_dbg_en, 1'b1, "R7 legacy follows auth");
        chk(sec_count_en, 1'b1, "R9 count override");
        auth_sec_cnt = 1'b0; auth_sec_dbg = 1'b0;

        // R11 Non-secure state ignores mode field
        access(1'b1, 2'd3, 1'b0, 32'h0000_C000, 1'b1, "R11 write mode 11");
        ns_state = 1'b1; auth_ns_dbg = 1'b0;
        settle();
        chk(cur_priv_dbg_en, 1'b0, "R11 NS ignores mode 11");
        chk(swbkpt_dbg_en, 1'b1, "R11 software breakpoint");
        auth_ns_dbg = 1'b1;
        settle();
        chk(cur_priv_dbg_en, 1'b1, "R11 NS follows auth");
        ns_state = 1'b0; auth_ns_dbg = 1'b0;
        settle();
        chk(cur_priv_dbg_en, 1'b1, "R11 secure mode 11");

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule